// File: doc/BRIEF.md
# Vector Element Sequencer with Data-Driven Early Exit

This controller runs a vector operation one element at a time, in program order, from element 0 up to VL-1. For each element it raises an issue strobe with the element index. It then waits for the execution unit to return a raw result and a 4-bit condition field. It decides what is written back from a 5-bit mode word captured at start. The mode selects one of four behaviours. Plain mode writes the result unchanged. Early-exit mode stops the loop at the first element whose condition test fails and shrinks VL to the count of leading elements that passed. Clamping mode limits the result to an unsigned or signed range of the chosen element width. Result-as-predicate mode cancels the data write of a failed element but still stores its condition field.

For every element that completes, the block gives the condition-field register number to write. Vector integer results map upward from field 8 and vector floating-point results from field 32. A scalar destination uses field 0 for integer and field 1 for floating point. When the operation ends, a one-cycle done pulse appears together with the final VL. A sticky flag reports whether any element of the operation was clamped.

The state machine has five states. IDLE waits for start. ISSUE presents one element. WAIT holds until the result arrives. WRITE presents one element's write-back. DONE pulses completion.

The transitions are:
- IDLE→ISSUE on start with VL>0, and IDLE→DONE on start with VL=0.
- ISSUE→WAIT always.
- WAIT→WRITE when a result arrives and the loop continues.
- WAIT→DONE when a result arrives and fails the early-exit test.
- WRITE→ISSUE when more elements remain, and WRITE→DONE after the last element.
- DONE→IDLE always.

Top module: `vec_elem_seq`

## Requirements
- R1: A start with VL=0 issues no element and produces done on the next cycle with vl_out=0.
- R2: Elements are issued one at a time in order 0,1,…,VL-1. Each iss_valid lasts one cycle, and the next element is not issued before the previous result has arrived.
- R3: A requested VL above 64 is treated as 64.
- R4: mode_bits[4:3] selects the behaviour: 00 plain, 01 early exit, 10 clamp, 11 result-as-predicate. In plain mode, every element writes res_data[31:0] with wr_idx equal to the element index. The condition field is written (cr_we, cr_data=res_cr) exactly when rc was 1 at start.
- R5: The condition test for early exit and result-as-predicate depends on rc. With rc=1, mode_bits[1:0] picks a bit of res_cr: 0→bit3 (less), 1→bit2 (greater), 2→bit1 (equal), 3→bit0 (overflow). With rc=0, the tested bit is "result nonzero", which is res_cr bit1 clear. In both cases mode_bits[2] inverts the test, and the element passes when the tested bit is 1.
- R6: In early-exit mode, a failed test at element i writes neither data nor a condition field for element i. No later element is issued, done follows on the next cycle, and vl_out=i.
- R7: In result-as-predicate mode, a failed element writes no data. The exception is rc=0 with mode_bits[0]=1, where the element writes zero instead. The condition field is still written when rc=1.
- R8: In clamp mode with mode_bits[2]=0, the signed result is limited to 0…2^w-1. The width w is set by elw: 01→8, 10→16, 11→32, 00→32.
- R9: In clamp mode with mode_bits[2]=1, the result is limited to −2^(w-1)…2^(w-1)-1.
- R10: sat_flag clears on an accepted start and becomes 1 once any element of that operation has been clamped. It then holds until the next accepted start.
- R11: The condition-field index is fixed for a scalar destination: 0 for integer, 1 for floating point. For a vector destination it is (8+i) mod 64 for integer and (32+i) mod 64 for floating point.
- R12: After the last element's write cycle, done pulses for exactly one cycle with vl_out equal to the effective VL. vl_out holds its value until the next operation ends.
- R13: start is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| vl_in | input | 7 | Requested vector length |
| mode_bits | input | 5 | Mode word; [4:3] behaviour, [2] invert/signed, [1:0] bit select or zeroing flags |
| rc | input | 1 | Condition-field recording enabled |
| is_fp | input | 1 | Floating-point operation |
| dest_scalar | input | 1 | Destination is scalar |
| elw | input | 2 | Element-width code for clamping |
| iss_valid | output | 1 | Element issue strobe |
| iss_idx | output | 7 | Index of the issued element |
| res_valid | input | 1 | Result of the issued element is present |
| res_data | input | 40 | Raw signed result |
| res_cr | input | 4 | Condition field: [3] less, [2] greater, [1] equal, [0] overflow |
| wr_en | output | 1 | Write element result |
| wr_idx | output | 7 | Element index of the write |
| wr_data | output | 32 | Result to write |
| cr_we | output | 1 | Write condition field |
| cr_idx | output | 6 | Condition-field register number |
| cr_data | output | 4 | Condition field to store |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | 7 | Final (possibly shortened) VL |
| sat_flag | output | 1 | Some element of the last operation was clamped |

## Verification
The assertions watch every cycle for the following properties:
- issue and done are single-cycle pulses;
- an issued index never reaches VL;
- the reported VL never exceeds 64;
- a failed early-exit element is followed directly by done with no write;
- the clamp flag stays set until the next accepted start.

Only the bench's scenarios can show the values themselves. These are the clamp limits at each width and signedness, the selected and inverted condition bit, the zero-fill of a cancelled element, the condition-field numbering and its wrap, and that an early exit at element 0 or mid-vector yields exactly the count of passing elements.

// File: rtl/ves_pkg.sv
package ves_pkg;
    typedef enum logic [1:0] {
        MK_PLAIN = 2'b00,
        MK_EXIT  = 2'b01,
        MK_CLAMP = 2'b10,
        MK_PRED  = 2'b11
    } mode_kind_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ISSUE = 3'd1,
        S_WAIT  = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } seq_state_t;

    localparam int CRF_INT_VEC  = 8;
    localparam int CRF_FP_VEC   = 32;
    localparam int CRF_INT_SCAL = 0;
    localparam int CRF_FP_SCAL  = 1;
endpackage

// File: rtl/ves_mode_dec.sv
module ves_mode_dec
    import ves_pkg::*;
(
    input  logic [4:0]  mode_bits,
    output mode_kind_t  kind,
    output logic        inv,
    output logic [1:0]  sel,
    output logic        zero_fill
);
    always_comb begin
        kind      = mode_kind_t'(mode_bits[4:3]);
        inv       = mode_bits[2];
        sel       = mode_bits[1:0];
        zero_fill = mode_bits[0];
    end
endmodule

// File: rtl/ves_cond_test.sv
module ves_cond_test (
    input  logic [3:0] cr,
    input  logic       rc,
    input  logic       inv,
    input  logic [1:0] sel,
    output logic       pass
);
    logic picked;

    always_comb begin
        if (rc) begin
            unique case (sel)
                2'd0: picked = cr[3];
                2'd1: picked = cr[2];
                2'd2: picked = cr[1];
                default: picked = cr[0];
            endcase
        end else begin
            picked = ~cr[1];
        end
        pass = picked ^ inv;
    end
endmodule

// File: rtl/ves_sat.sv
module ves_sat #(
    parameter int RW = 40,
    parameter int DW = 32
) (
    input  logic signed [RW-1:0] din,
    input  logic        [1:0]    wcode,
    input  logic                 signd,
    input  logic                 en,
    output logic        [DW-1:0] dout,
    output logic                 hit
);
    localparam logic [RW-1:0] ONE = RW'(1);

    int                  sh;
    logic signed [RW-1:0] hi;
    logic signed [RW-1:0] lo;
    logic signed [RW-1:0] kept;

    always_comb begin
        unique case (wcode)
            2'b01:   sh = 8;
            2'b10:   sh = 16;
            default: sh = DW;
        endcase
        if (signd) begin
            hi = (ONE << (sh - 1)) - ONE;
            lo = ~((ONE << (sh - 1)) - ONE);
        end else begin
            hi = (ONE << sh) - ONE;
            lo = '0;
        end
        hit  = 1'b0;
        kept = din;
        if (en) begin
            if (din > hi) begin
                kept = hi;
                hit  = 1'b1;
            end else if (din < lo) begin
                kept = lo;
                hit  = 1'b1;
            end
        end
        dout = kept[DW-1:0];
    end
endmodule

// File: rtl/ves_cr_map.sv
module ves_cr_map
    import ves_pkg::*;
#(
    parameter int CRIW = 6
) (
    input  logic            is_fp,
    input  logic            scalar,
    input  logic [CRIW-1:0] idx,
    output logic [CRIW-1:0] cr_idx
);
    logic [CRIW-1:0] base;

    always_comb begin
        base = is_fp ? CRIW'(CRF_FP_VEC) : CRIW'(CRF_INT_VEC);
        if (scalar)
            cr_idx = is_fp ? CRIW'(CRF_FP_SCAL) : CRIW'(CRF_INT_SCAL);
        else
            cr_idx = base + idx;
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import ves_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int DW    = 32,
    parameter int RW    = 40,
    parameter int CRN   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [$clog2(MAXVL):0]    vl_in,
    input  logic [4:0]                mode_bits,
    input  logic                      rc,
    input  logic                      is_fp,
    input  logic                      dest_scalar,
    input  logic [1:0]                elw,
    output logic                      iss_valid,
    output logic [$clog2(MAXVL):0]    iss_idx,
    input  logic                      res_valid,
    input  logic [RW-1:0]             res_data,
    input  logic [3:0]                res_cr,
    output logic                      wr_en,
    output logic [$clog2(MAXVL):0]    wr_idx,
    output logic [DW-1:0]             wr_data,
    output logic                      cr_we,
    output logic [$clog2(CRN)-1:0]    cr_idx,
    output logic [3:0]                cr_data,
    output logic                      done,
    output logic [$clog2(MAXVL):0]    vl_out,
    output logic                      sat_flag
);
    localparam int IW   = $clog2(MAXVL) + 1;
    localparam int CRIW = $clog2(CRN);
    localparam logic [IW-1:0] VL_CAP = IW'(MAXVL);

    seq_state_t state, nxt;

    logic [IW-1:0]   idx_q, vl_q, vl_out_q;
    logic [4:0]      mode_q;
    logic            rc_q, fp_q, sc_q, sat_q;
    logic [1:0]      elw_q;
    logic            wr_en_q, cr_we_q;
    logic [DW-1:0]   wr_data_q;
    logic [CRIW-1:0] cr_idx_q;
    logic [3:0]      cr_data_q;

    mode_kind_t      kind;
    logic            inv, zero_fill, pass, clamp_hit, last_elem, exit_stop;
    logic [1:0]      sel;
    logic [DW-1:0]   clamped;
    logic [CRIW-1:0] cr_idx_n;
    logic [IW-1:0]   vl_eff;

    ves_mode_dec u_dec (
        .mode_bits (mode_q),
        .kind      (kind),
        .inv       (inv),
        .sel       (sel),
        .zero_fill (zero_fill)
    );

    ves_cond_test u_test (
        .cr   (res_cr),
        .rc   (rc_q),
        .inv  (inv),
        .sel  (sel),
        .pass (pass)
    );

    ves_sat #(.RW(RW), .DW(DW)) u_sat (
        .din   (res_data),
        .wcode (elw_q),
        .signd (inv),
        .en    (kind == MK_CLAMP),
        .dout  (clamped),
        .hit   (clamp_hit)
    );

    ves_cr_map #(.CRIW(CRIW)) u_crmap (
        .is_fp  (fp_q),
        .scalar (sc_q),
        .idx    (idx_q[CRIW-1:0]),
        .cr_idx (cr_idx_n)
    );

    assign vl_eff    = (vl_in > VL_CAP) ? VL_CAP : vl_in;
    assign last_elem = ((idx_q + IW'(1)) == vl_q);
    assign exit_stop = (kind == MK_EXIT) && !pass;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = (vl_eff == '0) ? S_DONE : S_ISSUE;
            S_ISSUE: nxt = S_WAIT;
            S_WAIT:  if (res_valid) nxt = exit_stop ? S_DONE : S_WRITE;
            S_WRITE: nxt = last_elem ? S_DONE : S_ISSUE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // element datapath and configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            vl_q      <= '0;
            vl_out_q  <= '0;
            mode_q    <= '0;
            rc_q      <= 1'b0;
            fp_q      <= 1'b0;
            sc_q      <= 1'b0;
            elw_q     <= '0;
            sat_q     <= 1'b0;
            wr_en_q   <= 1'b0;
            cr_we_q   <= 1'b0;
            wr_data_q <= '0;
            cr_idx_q  <= '0;
            cr_data_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        vl_q   <= vl_eff;
                        idx_q  <= '0;
                        mode_q <= mode_bits;
                        rc_q   <= rc;
                        fp_q   <= is_fp;
                        sc_q   <= dest_scalar;
                        elw_q  <= elw;
                        sat_q  <= 1'b0;
                        if (vl_eff == '0) vl_out_q <= '0;
                    end
                end
                S_WAIT: begin
                    if (res_valid) begin
                        cr_we_q   <= rc_q;
                        cr_data_q <= res_cr;
                        cr_idx_q  <= cr_idx_n;
                        if (kind == MK_PRED && !pass) begin
                            wr_en_q   <= !rc_q && zero_fill;
                            wr_data_q <= '0;
                        end else begin
                            wr_en_q   <= 1'b1;
                            wr_data_q <= clamped;
                        end
                        if (clamp_hit) sat_q <= 1'b1;
                        if (exit_stop) vl_out_q <= idx_q;
                    end
                end
                S_WRITE: begin
                    idx_q <= idx_q + IW'(1);
                    if (last_elem) vl_out_q <= vl_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        iss_valid = (state == S_ISSUE);
        iss_idx   = idx_q;
        wr_en     = (state == S_WRITE) && wr_en_q;
        wr_idx    = idx_q;
        wr_data   = wr_data_q;
        cr_we     = (state == S_WRITE) && cr_we_q;
        cr_idx    = cr_idx_q;
        cr_data   = cr_data_q;
        done      = (state == S_DONE);
        vl_out    = vl_out_q;
        sat_flag  = sat_q;
    end

    // R2
    issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !iss_valid);

    // R2
    issue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_idx < vl_q));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    vl_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= VL_CAP));

    // R6
    exit_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && res_valid && exit_stop) |=> (done && !wr_en && !cr_we && vl_out == $past(idx_q)));

    // R10
    sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !(state == S_IDLE && start)) |=> sat_flag);
endmodule

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl_in = '0;
    logic [4:0]  mode_bits = '0;
    logic        rc = 1'b0, is_fp = 1'b0, dest_scalar = 1'b0;
    logic [1:0]  elw = '0;
    logic        res_valid = 1'b0;
    logic [39:0] res_data = '0;
    logic [3:0]  res_cr = '0;
    logic        iss_valid, wr_en, cr_we, done, sat_flag;
    logic [6:0]  iss_idx, wr_idx, vl_out;
    logic [31:0] wr_data;
    logic [5:0]  cr_idx;
    logic [3:0]  cr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [39:0] dat_a [64];
    logic [3:0]  cr_a  [64];
    int last_vl = 0;

    always #10 clk = ~clk;

    vec_elem_seq u_vec_elem_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .mode_bits(mode_bits), .rc(rc), .is_fp(is_fp), .dest_scalar(dest_scalar),
        .elw(elw), .iss_valid(iss_valid), .iss_idx(iss_idx), .res_valid(res_valid),
        .res_data(res_data), .res_cr(res_cr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .cr_we(cr_we), .cr_idx(cr_idx), .cr_data(cr_data),
        .done(done), .vl_out(vl_out), .sat_flag(sat_flag));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint clamp_ref(input logic [39:0] d, input logic [1:0] wc,
                                         input bit sg, output bit hit);
        longint v = longint'($signed(d));
        int w = (wc == 2'b01) ? 8 : (wc == 2'b10) ? 16 : 32;
        longint hi = sg ? ((longint'(1) << (w - 1)) - 1) : ((longint'(1) << w) - 1);
        longint lo = sg ? -(longint'(1) << (w - 1)) : 0;
        longint r = (v > hi) ? hi : (v < lo) ? lo : v;
        hit = (r != v);
        return r;
    endfunction

    function automatic bit test_ref(input logic [3:0] c, input bit r, input logic [4:0] m);
        bit b;
        if (!r) b = (c[1] == 1'b0);
        else begin
            case (m[1:0])
                2'd0: b = c[3];
                2'd1: b = c[2];
                2'd2: b = c[1];
                default: b = c[0];
            endcase
        end
        return m[2] ? !b : b;
    endfunction

    function automatic int cr_ref(input bit f, input bit s, input int e);
        if (s) return f ? 1 : 0;
        return ((f ? 32 : 8) + e) % 64;
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 64; i++) begin
            dat_a[i] = 40'($signed({$urandom, $urandom}) >>> ($urandom % 40));
            cr_a[i]  = 4'($urandom);
        end
    endtask

    task automatic run_op(input int vl, input logic [4:0] m, input bit r, input bit f,
                          input bit s, input logic [1:0] ew, input bit poke);
        int  eff = (vl > 64) ? 64 : vl;
        int  elem = 0;
        int  exp_vl = eff;
        bit  stopped = 0;
        bit  sat_e = 0;
        int  guard = 0;
        string tag;
        @(negedge clk);
        start = 1; vl_in = 7'(vl); mode_bits = m; rc = r; is_fp = f;
        dest_scalar = s; elw = ew;
        @(negedge clk);
        start = 0;
        while (!done && guard < 3000) begin
            guard++;
            if (iss_valid) begin
                bit pass, hit, e_wr;
                longint e_dat;
                string wtag;
                check(iss_idx == 7'(elem), "R2", "issue index", iss_idx, elem);
                @(negedge clk);
                if (poke && elem == 0) begin
                    start = 1; vl_in = 7'd3; mode_bits = 5'b01000;
                    @(negedge clk);
                    start = 0;
                end
                repeat ($urandom % 3) @(negedge clk);
                res_valid = 1; res_data = dat_a[elem]; res_cr = cr_a[elem];
                @(negedge clk);
                res_valid = 0;
                pass = test_ref(cr_a[elem], r, m);
                hit = 0;
                e_wr = 1;
                e_dat = longint'($signed(dat_a[elem]));
                wtag = "R4";
                case (m[4:3])
                    2'b01: wtag = "R5";
                    2'b10: begin
                        e_dat = clamp_ref(dat_a[elem], ew, m[2], hit);
                        wtag = m[2] ? "R9" : "R8";
                    end
                    2'b11: begin
                        wtag = "R7";
                        if (!pass) begin
                            e_wr = !r && m[0];
                            e_dat = 0;
                        end
                    end
                    default: ;
                endcase
                if (m[4:3] == 2'b01 && !pass) begin
                    check(done && !wr_en && !cr_we, "R6", "stop without write",
                          {done, wr_en, cr_we}, 3'b100);
                    exp_vl = elem;
                    stopped = 1;
                end else begin
                    if (hit) sat_e = 1;
                    check(wr_en == e_wr, wtag, "write enable", wr_en, e_wr);
                    if (e_wr) begin
                        check(wr_data == 32'(e_dat), wtag, "write data", wr_data, 32'(e_dat));
                        check(wr_idx == 7'(elem), wtag, "write index", wr_idx, elem);
                    end
                    check(cr_we == r, "R7", "cond write enable", cr_we, r);
                    if (r) begin
                        check(cr_idx == 6'(cr_ref(f, s, elem)), "R11", "cond index",
                              cr_idx, cr_ref(f, s, elem));
                        check(cr_data == cr_a[elem], "R4", "cond data", cr_data, cr_a[elem]);
                    end
                    elem++;
                    @(negedge clk);
                end
            end else begin
                @(negedge clk);
            end
        end
        tag = poke ? "R13" : (vl == 0) ? "R1" : (vl > 64) ? "R3" : stopped ? "R6" : "R12";
        check(done == 1'b1, tag, "done pulse", done, 1);
        check(vl_out == 7'(exp_vl), tag, "final VL", vl_out, exp_vl);
        check(elem == exp_vl, tag, "elements completed", elem, exp_vl);
        check(sat_flag == sat_e, "R10", "clamp flag", sat_flag, sat_e);
        @(negedge clk);
        check(done == 1'b0 && vl_out == 7'(exp_vl), "R12", "done single cycle, VL held",
              {done, vl_out}, exp_vl);
        last_vl = exp_vl;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!done && !iss_valid && !wr_en && !cr_we, "R12", "reset outputs idle",
              {done, iss_valid, wr_en, cr_we}, 0);
        check(vl_out == 0 && !sat_flag, "R12", "reset VL and flag", vl_out, 0);

        // R1: zero-length vector
        fill_random();
        run_op(0, 5'b00000, 1, 0, 0, 2'b00, 0);
        // R3: oversized VL, vector int cond fields wrap (R11)
        run_op(70, 5'b00000, 1, 0, 0, 2'b00, 0);
        // R11: vector FP wrap and scalar destinations
        run_op(40, 5'b00000, 1, 1, 0, 2'b00, 0);
        run_op(3, 5'b00000, 1, 1, 1, 2'b00, 0);
        run_op(3, 5'b00000, 1, 0, 1, 2'b00, 0);

        // R6: early exit at element 0 (test EQ, rc=1)
        for (int i = 0; i < 64; i++) cr_a[i] = 4'b0010;
        cr_a[0] = 4'b0100;
        run_op(8, 5'b01010, 1, 0, 0, 2'b00, 0);
        // R6: early exit mid-vector at element 5
        cr_a[0] = 4'b0010;
        cr_a[5] = 4'b1000;
        run_op(10, 5'b01010, 1, 0, 0, 2'b00, 0);
        // R5: inverted, rc=0 nonzero test: fail when EQ clear
        for (int i = 0; i < 64; i++) cr_a[i] = 4'b0010;
        cr_a[4] = 4'b0100;
        run_op(9, 5'b01100, 0, 0, 0, 2'b00, 0);

        // R7: result-as-predicate variants
        for (int i = 0; i < 64; i++) cr_a[i] = (i % 2) ? 4'b0100 : 4'b1000;
        run_op(6, 5'b11001, 1, 0, 0, 2'b00, 0);
        run_op(6, 5'b11001, 0, 0, 0, 2'b00, 0);
        run_op(6, 5'b11000, 0, 0, 0, 2'b00, 0);

        // R8: unsigned 8-bit boundaries
        dat_a[0] = 40'd255; dat_a[1] = 40'd256; dat_a[2] = -40'sd1; dat_a[3] = 40'd0;
        run_op(4, 5'b10000, 0, 0, 0, 2'b01, 0);
        // R9: signed 16-bit boundaries
        dat_a[0] = 40'd32767; dat_a[1] = 40'd32768; dat_a[2] = -40'sd32768; dat_a[3] = -40'sd32769;
        run_op(4, 5'b10100, 0, 0, 0, 2'b10, 0);
        // R10: next operation without clamping clears the flag
        dat_a[0] = 40'd5;
        run_op(1, 5'b10000, 0, 0, 0, 2'b01, 0);
        // R13: start during a run is ignored
        fill_random();
        run_op(5, 5'b00000, 0, 0, 0, 2'b00, 1);

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            fill_random();
            if (n % 3 == 0)
                for (int i = 0; i < 64; i++) cr_a[i] = ($urandom % 6 == 0) ? 4'b1000 : 4'b0010;
            run_op($urandom % 24, 5'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom % 4 == 0), 2'($urandom), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule